// File: doc/BRIEF.md
# LBA48 Task-File Loader

This block loads the task-file registers of a disk controller for a command that uses 48-bit block addressing. When `start` is pulsed while the block is idle, it captures a 48-bit block address, a 16-bit sector count, a drive-select bit and a command byte. It then issues ten byte writes to the register file, one after another. Each sector-count and address register holds two bytes, so it is loaded twice: first with the upper half, then with the lower half. The writes move from port to port, so the same offset is never written twice in a row.

The writes leave on a valid/ready stream made of `wr_valid`, `wr_ready`, `wr_addr` and `wr_data`. Each write is presented for a window of `STB_CYCLES` cycles. It is accepted in the last cycle of that window in which `wr_ready` is high. Once `wr_valid` is raised, it stays high and `wr_addr` and `wr_data` stay frozen until the write is accepted. A low `wr_ready` therefore stretches a write without limit. `done` pulses once after the command byte has been accepted. A sector count of zero is passed through as two zero bytes, and the register file reads those as 65536 sectors.

Top module: `lba48_taskfile_loader`

## Requirements
- R1: A started sequence consists of exactly ten accepted writes, in this order of (offset, byte): (2, count[15:8]), (3, lba[31:24]), (4, lba[39:32]), (5, lba[47:40]), (2, count[7:0]), (3, lba[7:0]), (4, lba[15:8]), (5, lba[23:16]), (6, drive/head), (7, command).
- R2: Offset 2 receives the sector-count high byte before its low byte. A count of 0 is sent as 0x00 then 0x00, which stands for 65536 sectors.
- R3: Offsets 3, 4 and 5 receive address bits 47:24 (one byte each, in ascending byte order) before they receive address bits 23:0.
- R4: Two consecutively accepted writes never carry the same offset.
- R5: The drive/head byte at offset 6 equals 0xE0 OR (drive-select << 4). Bits 7, 6 and 5 are set, bit 4 is the drive select, and bits 3:0 are zero.
- R6: The command byte is the last write of a sequence, at offset 7.
- R7: Each write holds `wr_valid` for at least `STB_CYCLES` cycles. It is accepted at the first clock edge where it has been valid for `STB_CYCLES` or more cycles and `wr_ready` is high.
- R8: While `wr_valid` is high and the write has not been accepted, `wr_addr` and `wr_data` stay stable and `wr_valid` stays high.
- R9: One cycle after the command write is accepted, `done` is high for exactly one cycle, and `busy` and `wr_valid` are low in that cycle.
- R10: `start` and the request inputs are ignored while `busy` is high. The bytes written come from the values captured when the sequence was started.
- R11: After reset, `busy`, `done` and `wr_valid` are low.
- R12: A `start` sampled while not busy makes `wr_valid` high in the next cycle, with the first write (offset 2) presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (ignored while busy) |
| blk_addr | input | 48 | 48-bit block address |
| sec_count | input | 16 | Sector count, 0 means 65536 |
| drv_sel | input | 1 | Drive select, placed in bit 4 of the drive/head byte |
| cmd_code | input | 8 | Command byte, written last |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the command write |
| wr_valid | output | 1 | Register write presented |
| wr_ready | input | 1 | Register file accepts the write |
| wr_addr | output | 3 | Task-file register offset |
| wr_data | output | 8 | Byte to write |

## Verification
The bench builds the loader with `STB_CYCLES` = 3. With that value, a write that is accepted on the first possible edge can be told apart from one accepted early or late, and the hold period before the window ends can also be told apart from a hold caused by back-pressure. The sweep crosses every address/count pattern (zero count, all-ones count, walking and mixed bytes) with both drive-select values and four `wr_ready` patterns. Those patterns are always ready, periodic stalls, bursty stalls and a long initial stall. A second `start`, together with changed request inputs, is injected in the middle of some sequences.

// File: rtl/lba48_pkg.sv
package lba48_pkg;

  // Task-file register offsets used by this loader
  localparam logic [2:0] TF_COUNT  = 3'd2;
  localparam logic [2:0] TF_DEVSEL = 3'd6;
  localparam logic [2:0] TF_CMD    = 3'd7;

  // Eight split writes plus drive/head plus command
  localparam int unsigned NUM_WRITES = 10;
  localparam int unsigned SPLIT_WRITES = 8;

  typedef struct packed {
    logic [47:0] lba;
    logic [15:0] count;
    logic        drv;
    logic [7:0]  cmd;
  } tf_req_t;

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] data;
  } tf_write_t;

  // Drive/head byte for 48-bit addressing: legacy bits 7 and 5, LBA bit 6
  function automatic logic [7:0] devsel_byte(input logic drv);
    return {3'b111, drv, 4'b0000};
  endfunction

endpackage

// File: rtl/lba48_seq_ctrl.sv
module lba48_seq_ctrl #(
  parameter int unsigned STB_CYCLES = 2,
  parameter int unsigned NUM_STEPS  = 10,
  localparam int unsigned CW = (STB_CYCLES < 2) ? 1 : $clog2(STB_CYCLES),
  localparam int unsigned SW = $clog2(NUM_STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr_ready,
  output logic          load,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] step
);

  localparam logic [CW-1:0] WIN_LAST  = CW'(STB_CYCLES - 1);
  localparam logic [SW-1:0] STEP_LAST = SW'(NUM_STEPS - 1);

  logic [CW-1:0] stb_q;
  logic [SW-1:0] step_q;
  logic          busy_q;
  logic          done_q;
  logic          win_end;
  logic          accept;

  assign win_end = (stb_q == WIN_LAST);
  assign accept  = busy_q && win_end && wr_ready;
  assign load    = start && !busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        step_q <= '0;
        stb_q  <= '0;
      end else if (busy_q) begin
        if (accept) begin
          stb_q <= '0;
          if (step_q == STEP_LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end else if (!win_end) begin
          stb_q <= stb_q + 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;
  assign step = step_q;

endmodule

// File: rtl/lba48_byte_mux.sv
module lba48_byte_mux
  import lba48_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  tf_req_t       req,
  input  logic [SW-1:0] step,
  output tf_write_t     wr
);

  logic       hi_half;
  logic [1:0] lane;
  logic [2:0] byte_idx;
  logic [5:0] shamt;
  logic [47:0] shifted;

  assign hi_half  = ~step[2];
  assign lane     = step[1:0];
  // Address lane n (1..3) carries byte n-1 of the low half or byte n+2 of the high half
  assign byte_idx = 3'(lane) - 3'd1 + (hi_half ? 3'd3 : 3'd0);
  assign shamt    = {byte_idx, 3'b000};
  assign shifted  = req.lba >> shamt;

  always_comb begin
    wr = '{addr: TF_CMD, data: req.cmd};
    if (step < SW'(SPLIT_WRITES)) begin
      if (lane == 2'd0) begin
        wr.addr = TF_COUNT;
        wr.data = hi_half ? req.count[15:8] : req.count[7:0];
      end else begin
        wr.addr = TF_COUNT + 3'(lane);
        wr.data = shifted[7:0];
      end
    end else if (step == SW'(SPLIT_WRITES)) begin
      wr.addr = TF_DEVSEL;
      wr.data = devsel_byte(req.drv);
    end
  end

endmodule

// File: rtl/lba48_req_reg.sv
module lba48_req_reg
  import lba48_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  tf_req_t req_in,
  output tf_req_t req_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= '0;
    else if (load) req_q <= req_in;
  end

endmodule

// File: rtl/lba48_taskfile_loader.sv
module lba48_taskfile_loader
  import lba48_pkg::*;
#(
  parameter int unsigned STB_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [47:0] blk_addr,
  input  logic [15:0] sec_count,
  input  logic        drv_sel,
  input  logic [7:0]  cmd_code,
  output logic        busy,
  output logic        done,
  output logic        wr_valid,
  input  logic        wr_ready,
  output logic [2:0]  wr_addr,
  output logic [7:0]  wr_data
);

  localparam int unsigned SW = $clog2(NUM_WRITES);

  logic          load;
  logic [SW-1:0] step;
  tf_req_t       req_in;
  tf_req_t       req_q;
  tf_write_t     cur_wr;

  assign req_in = '{lba: blk_addr, count: sec_count, drv: drv_sel, cmd: cmd_code};

  lba48_req_reg u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .req_in (req_in),
    .req_q  (req_q)
  );

  lba48_seq_ctrl #(
    .STB_CYCLES (STB_CYCLES),
    .NUM_STEPS  (NUM_WRITES)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_ready (wr_ready),
    .load     (load),
    .busy     (busy),
    .done     (done),
    .step     (step)
  );

  lba48_byte_mux #(.SW(SW)) u_mux (
    .req  (req_q),
    .step (step),
    .wr   (cur_wr)
  );

  assign wr_valid = busy;
  assign wr_addr  = cur_wr.addr;
  assign wr_data  = cur_wr.data;

endmodule

// File: rtl/lba48_taskfile_loader_chk.sv
module lba48_taskfile_loader_chk #(
  parameter int unsigned STB_CYCLES = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data
);

  logic [15:0] run_q;
  logic [2:0]  last_addr_q;
  logic        have_last_q;
  logic        acc;

  // A write is taken once it has been shown for the full window and ready is high
  assign acc = wr_valid && wr_ready && (32'(run_q) + 1 >= STB_CYCLES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= '0;
      last_addr_q <= '0;
      have_last_q <= 1'b0;
    end else begin
      if (acc || !wr_valid) run_q <= '0;
      else if (run_q != 16'hFFFF) run_q <= run_q + 1'b1;
      if (acc) begin
        last_addr_q <= wr_addr;
        have_last_q <= 1'b1;
      end else if (done) begin
        have_last_q <= 1'b0;
      end
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !acc |=> wr_valid && $stable(wr_addr) && $stable(wr_data)); // R8

  AST_PORT_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    acc && have_last_q |-> wr_addr != last_addr_q); // R4

  AST_DEVSEL_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_addr == 3'd6 |-> wr_data[7:5] == 3'b111 && wr_data[3:0] == 4'h0); // R5

  AST_DONE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(acc && wr_addr == 3'd7)); // R9

  AST_CMD_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    acc && wr_addr == 3'd7 |=> done && !busy && !wr_valid); // R6

  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> wr_valid && wr_addr == 3'd2); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

endmodule

bind lba48_taskfile_loader lba48_taskfile_loader_chk #(.STB_CYCLES(STB_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data)
);

// File: tb/sim_lba48_taskfile_loader.sv
module sim_lba48_taskfile_loader;

  localparam int STB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [47:0] blk_addr = '0;
  logic [15:0] sec_count = '0;
  logic        drv_sel = 1'b0;
  logic [7:0]  cmd_code = '0;
  logic        busy, done, wr_valid;
  logic        wr_ready = 1'b0;
  logic [2:0]  wr_addr;
  logic [7:0]  wr_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  lba48_taskfile_loader #(.STB_CYCLES(STB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .sec_count(sec_count), .drv_sel(drv_sel), .cmd_code(cmd_code),
    .busy(busy), .done(done), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 4:    return "R1 R2 R7 R8 R10";
      8:       return "R1 R5 R7 R8 R10";
      9:       return "R1 R6 R7 R8 R10";
      default: return "R1 R3 R7 R8 R10";
    endcase
  endfunction

  function automatic bit ready_of(input int mode, input int c);
    case (mode)
      0: return 1'b1;
      1: return (c % 3) != 2;
      2: return (c % 5) < 2;
      default: return c >= 7;
    endcase
  endfunction

  task automatic run_seq(input logic [47:0] l, input logic [15:0] c, input logic d,
                         input logic [7:0] k, input int mode, input bit poke);
    logic [2:0] ea [10];
    logic [7:0] ed [10];
    int idx, run, cy;
    logic [2:0] prev_addr;
    ea = '{3'd2, 3'd3, 3'd4, 3'd5, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    ed[0] = c[15:8];  ed[1] = l[31:24]; ed[2] = l[39:32]; ed[3] = l[47:40];
    ed[4] = c[7:0];   ed[5] = l[7:0];   ed[6] = l[15:8];  ed[7] = l[23:16];
    ed[8] = 8'hE0 | (8'(d) << 4);
    ed[9] = k;

    @(negedge clk);
    blk_addr = l; sec_count = c; drv_sel = d; cmd_code = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    check(wr_valid && busy && wr_addr == 3'd2, "R12", {wr_valid, busy, wr_addr}, {1'b1, 1'b1, 3'd2});
    idx = 0; run = 0; cy = 0; prev_addr = 3'd0;
    while (idx < 10 && cy < 2000) begin
      wr_ready = ready_of(mode, cy);
      if (poke && cy == 3) begin
        blk_addr = ~l; sec_count = ~c; drv_sel = ~d; cmd_code = ~k;
      end
      start = poke && (cy == 5);
      #1;
      check(wr_valid, tag_of(idx), 64'(wr_valid), 64'd1);
      check(wr_addr == ea[idx] && wr_data == ed[idx], tag_of(idx),
            {wr_addr, wr_data}, {ea[idx], ed[idx]});
      if (run == 0 && idx > 0)
        check(wr_addr != prev_addr, "R4", 64'(wr_addr), 64'(prev_addr));
      run++;
      if (wr_ready && run >= STB) begin
        prev_addr = wr_addr;
        idx++;
        run = 0;
      end
      @(negedge clk);
      cy++;
    end
    start = 1'b0;
    wr_ready = 1'b0;
    #1;
    check(done && !busy && !wr_valid, "R9", {done, busy, wr_valid}, {1'b1, 1'b0, 1'b0});
    @(negedge clk);
    #1;
    check(!done && !busy, "R9 R10", {done, busy}, {1'b0, 1'b0});
  endtask

  initial begin
    logic [47:0] lbas [6];
    logic [15:0] cnts [6];
    lbas = '{48'h0, 48'hFFFF_FFFF_FFFF, 48'h0605_0403_0201, 48'h8000_0000_0001,
             48'hA5C3_3C5A_1E2D, 48'h0000_0100_0000};
    cnts = '{16'h0000, 16'hFFFF, 16'h1234, 16'h0001, 16'h8000, 16'h00FF};
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !wr_valid, "R11", {busy, done, wr_valid}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(!busy && !done && !wr_valid, "R11", {busy, done, wr_valid}, 3'b000);
    for (int p = 0; p < 6; p++)
      for (int d = 0; d < 2; d++)
        for (int m = 0; m < 4; m++)
          run_seq(lbas[p], cnts[p], d[0], 8'h24 + 8'(p * 8 + d * 4 + m), m, (p + m) % 2 == 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc_total);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule